// File: doc/BRIEF.md
# Input Capture Channel

This block is one capture channel of a timer. It picks one of three input sources: the channel's own pin, the neighbouring channel's pin, or the signal from the timer's trigger controller. The chosen input is synchronised and then cleaned by a digital filter whose length is set by a 4-bit field. The block then detects the selected edge, rising or falling. A prescaler passes only every 1st, 2nd, 4th or 8th edge. Each edge that gets through copies the running counter value into a 16-bit capture register.

A small state machine tracks whether the capture register holds an unread value. It has three states. ST_EMPTY means no value is pending. ST_FULL means one unread capture is pending. ST_OVRUN means a capture arrived while an earlier one was still unread. The transitions are:
- A capture moves ST_EMPTY to ST_FULL.
- A capture without a read moves ST_FULL to ST_OVRUN.
- A read with no capture moves ST_FULL or ST_OVRUN to ST_EMPTY.
- A capture and a read in the same cycle move any state to ST_FULL.
- A capture without a read keeps ST_OVRUN in ST_OVRUN.

Top module: `capture_channel`

## Requirements
- R1: `src_sel` picks the input. 2'b00 selects `pin_own`, 2'b01 selects `pin_nbr`, and 2'b10 or 2'b11 select `trig_in`. Activity on an input that is not selected never causes a capture.
- R2: A change of the synchronised input reaches the edge detector only if it persists for `filt_len`+1 consecutive clock cycles. A pulse of `filt_len` cycles or fewer is rejected.
- R3: With `edge_fall`=0 a rising edge of the filtered input is the active edge. With `edge_fall`=1 a falling edge is the active edge. The other edge never captures.
- R4: On an accepted event, `cap_val` takes the value of `cnt_in`. Otherwise `cap_val` holds its value.
- R5: `psc_sel` sets the event decimation. 2'b00 accepts every active edge, 2'b01 every 2nd, 2'b10 every 4th and 2'b11 every 8th.
- R6: A capture sets `cap_flag`. A `rd_strobe` pulse with no capture in the same cycle clears both `cap_flag` and `ovr_flag`.
- R7: A capture while `cap_flag` is set, with no read in that cycle, sets `ovr_flag`. A capture in the same cycle as `rd_strobe` leaves `cap_flag`=1 and `ovr_flag`=0.
- R8: While `en`=0 no capture occurs and the prescaler edge count returns to zero. Counting restarts from the first edge after `en` rises.
- R9: After reset, `cap_val`=0, `cap_flag`=0 and `ovr_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel capture enable |
| src_sel | input | 2 | Input source select |
| pin_own | input | 1 | Channel's own pin |
| pin_nbr | input | 1 | Neighbouring channel's pin |
| trig_in | input | 1 | Trigger controller signal |
| filt_len | input | 4 | Filter length (stable cycles minus one) |
| edge_fall | input | 1 | 1 = falling edge is active |
| psc_sel | input | 2 | Event prescaler select |
| cnt_in | input | 16 | Running counter value |
| rd_strobe | input | 1 | Capture register read pulse |
| cap_val | output | 16 | Capture register |
| cap_flag | output | 1 | Unread capture pending |
| ovr_flag | output | 1 | Overcapture occurred |

## Verification
A capture and a read of the capture register can land in the same clock cycle, and the flag machine must then treat the new value as the unread one. The bench first leaves a capture pending. It then raises the input and asserts `rd_strobe` exactly in the cycle in which the accepted edge is latched. That cycle is three edges after the pin changes when the filter length is zero. The expected result is `cap_flag`=1, `ovr_flag`=0, and `cap_val` equal to the new counter value. Without the read the same stimulus would raise the overcapture flag.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        SRC_OWN  = 2'b00,
        SRC_NBR  = 2'b01,
        SRC_TRG  = 2'b10,
        SRC_TRG2 = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'b00,
        ST_FULL  = 2'b01,
        ST_OVRUN = 2'b10
    } flag_st_e;

    localparam int unsigned PSC_MAX_LOG2 = 3;
endpackage

// File: rtl/cap_input_filter.sv
module cap_input_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        src_sel,
    input  logic              pin_own,
    input  logic              pin_nbr,
    input  logic              trig_in,
    input  logic [FILT_W-1:0] filt_len,
    output logic              filt_q
);
    import cap_pkg::*;

    logic                   raw_sel;
    logic [SYNC_STAGES-1:0] sync_sr;
    logic                   synced;
    logic [FILT_W-1:0]      run_cnt;

    always_comb begin
        unique case (src_e'(src_sel))
            SRC_OWN:  raw_sel = pin_own;
            SRC_NBR:  raw_sel = pin_nbr;
            SRC_TRG,
            SRC_TRG2: raw_sel = trig_in;
            default:  raw_sel = pin_own;
        endcase
    end

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_sr <= '0;
                else        sync_sr <= raw_sel;
            end
        end else begin : g_syncn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_sr <= '0;
                else        sync_sr <= {sync_sr[SYNC_STAGES-2:0], raw_sel};
            end
        end
    endgenerate

    assign synced = sync_sr[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q  <= 1'b0;
            run_cnt <= '0;
        end else if (synced == filt_q) begin
            run_cnt <= '0;
        end else if (run_cnt >= filt_len) begin
            filt_q  <= synced;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cap_edge_prescale.sv
module cap_edge_prescale #(
    parameter int unsigned PSC_W = cap_pkg::PSC_MAX_LOG2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       filt_q,
    input  logic       edge_fall,
    input  logic [1:0] psc_sel,
    output logic       cap_evt
);
    logic             filt_d;
    logic             act_edge;
    logic [PSC_W-1:0] ev_cnt;
    logic [PSC_W-1:0] ev_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) filt_d <= 1'b0;
        else        filt_d <= filt_q;
    end

    assign act_edge = edge_fall ? (filt_d & ~filt_q) : (~filt_d & filt_q);

    always_comb begin
        unique case (psc_sel)
            2'b00:   ev_last = PSC_W'(0);
            2'b01:   ev_last = PSC_W'(1);
            2'b10:   ev_last = PSC_W'(3);
            default: ev_last = PSC_W'(7);
        endcase
    end

    assign cap_evt = en && act_edge && (ev_cnt >= ev_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ev_cnt <= '0;
        else if (!en)        ev_cnt <= '0;
        else if (cap_evt)    ev_cnt <= '0;
        else if (act_edge)   ev_cnt <= ev_cnt + 1'b1;
    end
endmodule

// File: rtl/cap_flag_fsm.sv
module cap_flag_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_evt,
    input  logic rd_strobe,
    output logic cap_flag,
    output logic ovr_flag
);
    import cap_pkg::*;

    flag_st_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (cap_evt) state_nx = ST_FULL;
            ST_FULL: begin
                if (cap_evt && !rd_strobe) state_nx = ST_OVRUN;
                else if (cap_evt)          state_nx = ST_FULL;
                else if (rd_strobe)        state_nx = ST_EMPTY;
            end
            ST_OVRUN: begin
                if (cap_evt && rd_strobe) state_nx = ST_FULL;
                else if (rd_strobe)       state_nx = ST_EMPTY;
            end
            default: state_nx = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        cap_flag = 1'b0;
        ovr_flag = 1'b0;
        unique case (state)
            ST_EMPTY: ;
            ST_FULL:  cap_flag = 1'b1;
            ST_OVRUN: begin
                cap_flag = 1'b1;
                ovr_flag = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/capture_channel.sv
module capture_channel #(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned FILT_W      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        src_sel,
    input  logic              pin_own,
    input  logic              pin_nbr,
    input  logic              trig_in,
    input  logic [FILT_W-1:0] filt_len,
    input  logic              edge_fall,
    input  logic [1:0]        psc_sel,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              rd_strobe,
    output logic [CNT_W-1:0]  cap_val,
    output logic              cap_flag,
    output logic              ovr_flag
);
    logic filt_q;
    logic cap_evt;

    cap_input_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_W(FILT_W)) u_filt (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
        .pin_own(pin_own), .pin_nbr(pin_nbr), .trig_in(trig_in),
        .filt_len(filt_len), .filt_q(filt_q)
    );

    cap_edge_prescale u_edge (
        .clk(clk), .rst_n(rst_n), .en(en), .filt_q(filt_q),
        .edge_fall(edge_fall), .psc_sel(psc_sel), .cap_evt(cap_evt)
    );

    cap_flag_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .rd_strobe(rd_strobe),
        .cap_flag(cap_flag), .ovr_flag(ovr_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cap_val <= '0;
        else if (cap_evt) cap_val <= cnt_in;
    end
endmodule

// File: rtl/capture_channel_chk.sv
module capture_channel_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             cap_evt,
    input logic             rd_strobe,
    input logic [CNT_W-1:0] cnt_in,
    input logic [CNT_W-1:0] cap_val,
    input logic             cap_flag,
    input logic             ovr_flag
);
    a_r4_value_latched: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> cap_val == $past(cnt_in));

    a_r4_value_held: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt |=> $stable(cap_val));

    a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> cap_flag);

    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !cap_evt) |=> (!cap_flag && !ovr_flag));

    a_r7_ovr_after_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> $past(cap_flag));

    a_r7_same_cycle_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && rd_strobe) |=> (cap_flag && !ovr_flag));

    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !cap_evt);
endmodule

bind capture_channel capture_channel_chk #(.CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .cap_evt(cap_evt),
    .rd_strobe(rd_strobe), .cnt_in(cnt_in), .cap_val(cap_val),
    .cap_flag(cap_flag), .ovr_flag(ovr_flag)
);

// File: tb/test_capture_channel.sv
`timescale 1ns/1ps
module test_capture_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  src_sel = 2'b00;
    logic        pin_own = 1'b0, pin_nbr = 1'b0, trig_in = 1'b0;
    logic [3:0]  filt_len = 4'd0;
    logic        edge_fall = 1'b0;
    logic [1:0]  psc_sel = 2'b00;
    logic [15:0] cnt_in = 16'h0000;
    logic        rd_strobe = 1'b0;
    logic [15:0] cap_val;
    logic        cap_flag, ovr_flag;
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    capture_channel i_capture_channel (
        .clk(clk), .rst_n(rst_n), .en(en), .src_sel(src_sel),
        .pin_own(pin_own), .pin_nbr(pin_nbr), .trig_in(trig_in),
        .filt_len(filt_len), .edge_fall(edge_fall), .psc_sel(psc_sel),
        .cnt_in(cnt_in), .rd_strobe(rd_strobe),
        .cap_val(cap_val), .cap_flag(cap_flag), .ovr_flag(ovr_flag)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_pin(int which, logic v);
        case (which)
            0: pin_own = v;
            1: pin_nbr = v;
            default: trig_in = v;
        endcase
    endtask

    task automatic pulse(int which, int width, logic [15:0] cv);
        cnt_in = cv;
        set_pin(which, 1'b1);
        tick(width);
        set_pin(which, 1'b0);
        tick(width + 6);
    endtask

    task automatic do_read();
        rd_strobe = 1'b1;
        tick(1);
        rd_strobe = 1'b0;
        tick(1);
    endtask

    task automatic t_reset();
        check("R9 cap_val", cap_val, 0);
        check("R9 cap_flag", cap_flag, 0);
        check("R9 ovr_flag", ovr_flag, 0);
    endtask

    task automatic t_source();
        en = 1'b1;
        src_sel = 2'b00;
        pulse(0, 10, 16'h1111);
        check("R1 own pin", cap_val, 16'h1111);
        check("R6 flag set", cap_flag, 1);
        do_read();
        check("R6 read clears", cap_flag, 0);
        pulse(1, 10, 16'h2222);
        check("R1 nbr ignored when own selected", cap_flag, 0);
        src_sel = 2'b01;
        pulse(1, 10, 16'h3333);
        check("R1 nbr pin", cap_val, 16'h3333);
        do_read();
        src_sel = 2'b10;
        pulse(0, 10, 16'h4444);
        check("R1 own ignored when trig selected", cap_val, 16'h3333);
        pulse(2, 10, 16'h5555);
        check("R1 trigger", cap_val, 16'h5555);
        do_read();
        src_sel = 2'b00;
    endtask

    task automatic t_filter();
        filt_len = 4'd5;
        pulse(0, 5, 16'h0a0a);
        check("R2 short pulse rejected", cap_flag, 0);
        check("R2 value kept", cap_val, 16'h5555);
        pulse(0, 7, 16'h0b0b);
        check("R2 long pulse accepted", cap_val, 16'h0b0b);
        do_read();
        filt_len = 4'd0;
    endtask

    task automatic t_polarity();
        edge_fall = 1'b1;
        cnt_in = 16'h0c0c;
        pin_own = 1'b1;
        tick(10);
        check("R3 rising ignored when falling active", cap_flag, 0);
        pin_own = 1'b0;
        tick(10);
        check("R3 falling captures", cap_val, 16'h0c0c);
        do_read();
        edge_fall = 1'b0;
    endtask

    task automatic t_prescale();
        psc_sel = 2'b01;
        en = 1'b0; tick(2); en = 1'b1;
        pulse(0, 10, 16'h0101);
        check("R5 div2 first edge skipped", cap_flag, 0);
        pulse(0, 10, 16'h0202);
        check("R5 div2 second edge", cap_val, 16'h0202);
        do_read();
        psc_sel = 2'b11;
        en = 1'b0; tick(2); en = 1'b1;
        for (int i = 0; i < 7; i++) pulse(0, 4, 16'h0300 + 16'(i));
        check("R5 div8 seven edges", cap_flag, 0);
        pulse(0, 4, 16'h0808);
        check("R5 div8 eighth edge", cap_val, 16'h0808);
        do_read();
        psc_sel = 2'b00;
    endtask

    task automatic t_disable();
        en = 1'b0;
        pulse(0, 10, 16'h0d0d);
        check("R8 disabled no flag", cap_flag, 0);
        check("R8 disabled no value", cap_val, 16'h0808);
        en = 1'b1;
        psc_sel = 2'b10;
        pulse(0, 4, 16'h0e01);
        pulse(0, 4, 16'h0e02);
        en = 1'b0; tick(2); en = 1'b1;
        pulse(0, 4, 16'h0e03);
        pulse(0, 4, 16'h0e04);
        pulse(0, 4, 16'h0e05);
        check("R8 count restarted", cap_flag, 0);
        pulse(0, 4, 16'h0e06);
        check("R8 fourth edge after enable", cap_val, 16'h0e06);
        do_read();
        psc_sel = 2'b00;
    endtask

    task automatic t_overcapture();
        pulse(0, 6, 16'h0f01);
        pulse(0, 6, 16'h0f02);
        check("R7 overcapture set", ovr_flag, 1);
        check("R4 newest value", cap_val, 16'h0f02);
        do_read();
        check("R6 read clears ovr", ovr_flag, 0);
        check("R6 read clears flag", cap_flag, 0);
        pulse(0, 6, 16'h0f03);
        cnt_in = 16'h0f04;
        pin_own = 1'b1;
        tick(3);
        rd_strobe = 1'b1;
        tick(1);
        rd_strobe = 1'b0;
        tick(1);
        check("R7 same-cycle flag", cap_flag, 1);
        check("R7 same-cycle no ovr", ovr_flag, 0);
        check("R4 same-cycle value", cap_val, 16'h0f04);
        pin_own = 1'b0;
        tick(6);
        do_read();
    endtask

    initial begin
        tick(3);
        t_reset();
        rst_n = 1'b1;
        tick(2);
        t_source();
        t_filter();
        t_polarity();
        t_prescale();
        t_disable();
        t_overcapture();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule